// File: doc/BRIEF.md
# Channel FIFO with Burst Handshake and Packed Status

This block is a single-channel FIFO placed between a producer port, which faces a system bus, and a consumer port. Storage is a dual-port memory with independent write and read pointers. Each port moves data through a request/acknowledge handshake that also carries a channel number and a burst qualifier. A transfer is either one beat or a fixed burst of `BURST_LEN` beats. The block counts the acknowledges it issues to decide when a transfer has finished, and it never relies on the request falling. A pipelined requester can therefore hold its request for several cycles after the final acknowledge without moving extra data.

A request is rejected with a one-cycle error acknowledge, and no data moves, in two cases: the channel number does not match the configured `CHAN_ID`, or the FIFO cannot hold (for a write) or supply (for a read) the whole transfer. The producer side can pull a packed status word that holds the full/almost-full/half-full/empty flags and the free-entry count. The consumer side sees its own occupancy flags and the occupancy count at all times.

Top module: `chan_fifo`

## Requirements
- R1: After reset the FIFO holds nothing: `rdEmpty`, `rdAlmostEmpty` and `rdHalfEmpty` are 1, `rdOccupancy` is 0, no acknowledge or `rdValid` is asserted, and a status read reports Empty with vacancy equal to `DEPTH`.
- R2: A `statReq` sampled at a clock edge gives `statAck` high for the next cycle, with `statWord` holding the state from that edge. Bit DATA_W-1 is Full, DATA_W-2 is AlmostFull, DATA_W-3 is HalfFull, DATA_W-4 is Empty, bits DATA_W-5 down to DATA_W-32 hold the vacancy zero-extended, and all lower bits are 0.
- R3: An accepted single-beat request gets exactly one acknowledge. An accepted burst (`burst`=1) gets exactly `BURST_LEN` (8) acknowledges on consecutive cycles. A write beat is stored on each edge where `wrAck` is high.
- R4: A request still held after a transfer has finished is ignored: it causes no further acknowledge and moves no data until it has been low for at least one edge.
- R5: A request whose channel differs from `CHAN_ID` (3) gets exactly one error acknowledge, no acknowledge, and no data movement. The port's channel-valid output shows 1 only when its channel input equals `CHAN_ID`.
- R6: A write is accepted only if the vacancy is at least the transfer length, and a read only if the occupancy is at least the transfer length. Otherwise the port gets one error acknowledge and occupancy does not change. Occupancy never exceeds `DEPTH`, and a read is never acknowledged while empty.
- R7: Data is read in write order. `rdData` is valid, with `rdValid` high, in the cycle after each `rdAck`.
- R8: Full is occupancy equal to `DEPTH`. AlmostFull is vacancy ≤ 1. HalfFull is occupancy ≥ DEPTH/2. Empty is occupancy 0. AlmostEmpty is occupancy ≤ 1. HalfEmpty is occupancy ≤ DEPTH/2.
- R9: Occupancy and vacancy always add up to `DEPTH`. A write and a read acknowledged in the same cycle leave occupancy unchanged, and a lone write beat raises it by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrReq | input | 1 | Producer transfer request |
| wrBurst | input | 1 | 1 = fixed burst, 0 = single beat |
| wrChan | input | CH_W | Producer channel number |
| wrData | input | DATA_W | Write beat data |
| wrAck | output | 1 | Write beat taken |
| wrErrAck | output | 1 | Write request rejected |
| wrChanOk | output | 1 | Producer channel matches |
| statReq | input | 1 | Status word request |
| statAck | output | 1 | Status word valid |
| statWord | output | DATA_W | Packed flags and vacancy |
| rdReq | input | 1 | Consumer transfer request |
| rdBurst | input | 1 | 1 = fixed burst, 0 = single beat |
| rdChan | input | CH_W | Consumer channel number |
| rdAck | output | 1 | Read beat granted |
| rdErrAck | output | 1 | Read request rejected |
| rdChanOk | output | 1 | Consumer channel matches |
| rdData | output | DATA_W | Read beat data |
| rdValid | output | 1 | rdData valid |
| rdEmpty | output | 1 | Occupancy is zero |
| rdAlmostEmpty | output | 1 | Occupancy ≤ 1 |
| rdHalfEmpty | output | 1 | Occupancy ≤ DEPTH/2 |
| rdOccupancy | output | CNT_W | Stored entry count |

## Verification
Some properties are checked on every cycle: acknowledge and error acknowledge never overlap, an error acknowledge lasts one cycle, occupancy stays within bounds, no read is granted while empty, occupancy plus vacancy stays at the depth, a lone write beat steps occupancy by one, `rdValid` follows `rdAck` by one cycle, and every status request is answered. Other behaviour can only be shown by the bench's scenarios. These cover the exact acknowledge count per transfer, the trailing request being ignored, rejection on channel or capacity with no change to occupancy, FIFO data order through concurrent bursts, and the flag and vacancy values packed into the status word at empty, half, almost-full and full.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_XFER,
    PS_ERR,
    PS_DRAIN
  } portState_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic statEn;
  } strobe_t;

endpackage

// File: rtl/cfifo_port_fsm.sv
module cfifo_port_fsm
  import chan_fifo_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 5,
  parameter int CH_W      = 4,
  parameter int CHAN_ID   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic             burst,
  input  logic [CH_W-1:0]  chan,
  input  logic [CNT_W-1:0] avail,
  output logic             ack,
  output logic             errAck,
  output logic             chanOk
);

  localparam int BEAT_W = BURST_LEN;

  portState_e            state;
  logic [BEAT_W-1:0]     beatsLeft;
  logic [CNT_W-1:0]      need;
  logic                  fits;

  assign chanOk = (chan == CH_W'(CHAN_ID));
  assign need   = burst ? CNT_W'(BURST_LEN) : CNT_W'(1);
  assign fits   = (avail >= need);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PS_IDLE;
      beatsLeft <= '0;
    end else begin
      case (state)
        PS_IDLE: begin
          if (req) begin
            if (chanOk && fits) begin
              state     <= PS_XFER;
              beatsLeft <= burst ? (BEAT_W'(1) << (BURST_LEN - 1)) : BEAT_W'(1);
            end else begin
              state <= PS_ERR;
            end
          end
        end
        PS_XFER: begin
          beatsLeft <= beatsLeft >> 1;
          if (beatsLeft[0]) begin
            state <= req ? PS_DRAIN : PS_IDLE;
          end
        end
        PS_ERR: begin
          state <= req ? PS_DRAIN : PS_IDLE;
        end
        PS_DRAIN: begin
          if (!req) state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign ack    = (state == PS_XFER);
  assign errAck = (state == PS_ERR);

endmodule

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl
  import chan_fifo_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 5,
  parameter int CH_W      = 4,
  parameter int CHAN_ID   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             wrBurst,
  input  logic [CH_W-1:0]  wrChan,
  input  logic             rdReq,
  input  logic             rdBurst,
  input  logic [CH_W-1:0]  rdChan,
  input  logic             statReq,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] vacancy,
  output logic             wrAck,
  output logic             wrErrAck,
  output logic             wrChanOk,
  output logic             rdAck,
  output logic             rdErrAck,
  output logic             rdChanOk,
  output strobe_t          stb
);

  cfifo_port_fsm #(
    .BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .CH_W(CH_W), .CHAN_ID(CHAN_ID)
  ) uWrPort (
    .clk(clk), .rstN(rstN), .req(wrReq), .burst(wrBurst), .chan(wrChan),
    .avail(vacancy), .ack(wrAck), .errAck(wrErrAck), .chanOk(wrChanOk)
  );

  cfifo_port_fsm #(
    .BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .CH_W(CH_W), .CHAN_ID(CHAN_ID)
  ) uRdPort (
    .clk(clk), .rstN(rstN), .req(rdReq), .burst(rdBurst), .chan(rdChan),
    .avail(occupancy), .ack(rdAck), .errAck(rdErrAck), .chanOk(rdChanOk)
  );

  always_comb begin
    stb.wrEn   = wrAck;
    stb.rdEn   = rdAck;
    stb.statEn = statReq;
  end

endmodule

// File: rtl/cfifo_datapath.sv
module cfifo_datapath
  import chan_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] statWord,
  output logic              statAck,
  output logic [CNT_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  vacancy,
  output logic              empty,
  output logic              almostEmpty,
  output logic              halfEmpty
);

  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int STAT_W  = 32;
  localparam int VAC_W   = STAT_W - 4;
  localparam int HALF    = DEPTH / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              full, almostFull, halfFull;
  logic [STAT_W-1:0] statField;
  logic [DATA_W-1:0] statPacked;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.wrEn) wrPtr <= nextPtr(wrPtr);
      if (stb.rdEn) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
      rdValid <= stb.rdEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy <= '0;
      vacancy   <= CNT_W'(DEPTH);
    end else begin
      case ({stb.wrEn, stb.rdEn})
        2'b10: begin
          occupancy <= occupancy + 1'b1;
          vacancy   <= vacancy - 1'b1;
        end
        2'b01: begin
          occupancy <= occupancy - 1'b1;
          vacancy   <= vacancy + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign full        = (occupancy == CNT_W'(DEPTH));
  assign almostFull  = (vacancy <= CNT_W'(1));
  assign halfFull    = (occupancy >= CNT_W'(HALF));
  assign empty       = (occupancy == '0);
  assign almostEmpty = (occupancy <= CNT_W'(1));
  assign halfEmpty   = (occupancy <= CNT_W'(HALF));

  assign statField = {full, almostFull, halfFull, empty, VAC_W'(vacancy)};

  generate
    if (DATA_W > STAT_W) begin : gWide
      assign statPacked = {statField, {(DATA_W - STAT_W){1'b0}}};
    end else begin : gNarrow
      assign statPacked = statField;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statWord <= '0;
      statAck  <= 1'b0;
    end else begin
      statAck <= stb.statEn;
      if (stb.statEn) statWord <= statPacked;
    end
  end

endmodule

// File: rtl/chan_fifo.sv
module chan_fifo
  import chan_fifo_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int DEPTH     = 16,
  parameter int BURST_LEN = 8,
  parameter int CH_W      = 4,
  parameter int CHAN_ID   = 3,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              wrBurst,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAck,
  output logic              wrErrAck,
  output logic              wrChanOk,
  input  logic              statReq,
  output logic              statAck,
  output logic [DATA_W-1:0] statWord,
  input  logic              rdReq,
  input  logic              rdBurst,
  input  logic [CH_W-1:0]   rdChan,
  output logic              rdAck,
  output logic              rdErrAck,
  output logic              rdChanOk,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdEmpty,
  output logic              rdAlmostEmpty,
  output logic              rdHalfEmpty,
  output logic [CNT_W-1:0]  rdOccupancy
);

  strobe_t          stb;
  logic [CNT_W-1:0] vacCount;

  cfifo_ctrl #(
    .BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .CH_W(CH_W), .CHAN_ID(CHAN_ID)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrReq(wrReq), .wrBurst(wrBurst), .wrChan(wrChan),
    .rdReq(rdReq), .rdBurst(rdBurst), .rdChan(rdChan),
    .statReq(statReq), .occupancy(rdOccupancy), .vacancy(vacCount),
    .wrAck(wrAck), .wrErrAck(wrErrAck), .wrChanOk(wrChanOk),
    .rdAck(rdAck), .rdErrAck(rdErrAck), .rdChanOk(rdChanOk),
    .stb(stb)
  );

  cfifo_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid),
    .statWord(statWord), .statAck(statAck),
    .occupancy(rdOccupancy), .vacancy(vacCount),
    .empty(rdEmpty), .almostEmpty(rdAlmostEmpty), .halfEmpty(rdHalfEmpty)
  );

endmodule

// File: rtl/chan_fifo_chk.sv
module chan_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrAck,
  input logic             wrErrAck,
  input logic             rdAck,
  input logic             rdErrAck,
  input logic             rdValid,
  input logic             statReq,
  input logic             statAck,
  input logic             empty,
  input logic [CNT_W-1:0] occupancy,
  input logic [CNT_W-1:0] vacancy
);

  // R5: a port never both acknowledges and rejects in one cycle
  assert_ack_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAck && wrErrAck) && !(rdAck && rdErrAck));

  // R5: a rejection is a single-cycle pulse
  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrErrAck || rdErrAck) |=> !(wrErrAck || rdErrAck) || !($past(wrErrAck) && wrErrAck));

  // R6: occupancy bounded by depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  // R6: no read grant while empty
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> !empty);

  // R9: occupancy and vacancy together equal the depth
  assert_sum_R9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(occupancy) + 32'(vacancy)) == DEPTH);

  // R9: a lone write beat raises occupancy by one
  assert_wr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && !rdAck) |=> occupancy == CNT_W'($past(occupancy) + 1'b1));

  // R9: simultaneous write and read leave occupancy unchanged
  assert_both_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && rdAck) |=> $stable(occupancy));

  // R7: read data qualifier follows the grant by one cycle
  assert_rdvalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |=> rdValid);

  assert_rdvalid_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdAck |=> !rdValid);

  // R2: every status request is answered in the next cycle
  assert_stat_R2: assert property (@(posedge clk) disable iff (!rstN)
    statReq |=> statAck);

endmodule

bind chan_fifo chan_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .wrAck(wrAck), .wrErrAck(wrErrAck),
  .rdAck(rdAck), .rdErrAck(rdErrAck),
  .rdValid(rdValid), .statReq(statReq), .statAck(statAck),
  .empty(rdEmpty), .occupancy(rdOccupancy), .vacancy(vacCount)
);

// File: tb/tb_chan_fifo.sv
`timescale 1ns/1ps
module tb_chan_fifo;

  localparam int DATA_W = 36;
  localparam int DEPTH  = 16;
  localparam int BL     = 8;
  localparam int CH_W   = 4;
  localparam int CNT_W  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0, wrBurst = 1'b0;
  logic [CH_W-1:0] wrChan = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrAck, wrErrAck, wrChanOk;
  logic statReq = 1'b0;
  logic statAck;
  logic [DATA_W-1:0] statWord;
  logic rdReq = 1'b0, rdBurst = 1'b0;
  logic [CH_W-1:0] rdChan = '0;
  logic rdAck, rdErrAck, rdChanOk;
  logic [DATA_W-1:0] rdData;
  logic rdValid, rdEmpty, rdAlmostEmpty, rdHalfEmpty;
  logic [CNT_W-1:0] rdOccupancy;

  always #4 clk = ~clk;

  chan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST_LEN(BL), .CH_W(CH_W), .CHAN_ID(3)) dut (
    .clk(clk), .rstN(rstN),
    .wrReq(wrReq), .wrBurst(wrBurst), .wrChan(wrChan), .wrData(wrData),
    .wrAck(wrAck), .wrErrAck(wrErrAck), .wrChanOk(wrChanOk),
    .statReq(statReq), .statAck(statAck), .statWord(statWord),
    .rdReq(rdReq), .rdBurst(rdBurst), .rdChan(rdChan),
    .rdAck(rdAck), .rdErrAck(rdErrAck), .rdChanOk(rdChanOk),
    .rdData(rdData), .rdValid(rdValid),
    .rdEmpty(rdEmpty), .rdAlmostEmpty(rdAlmostEmpty), .rdHalfEmpty(rdHalfEmpty),
    .rdOccupancy(rdOccupancy)
  );

  int checks = 0;
  int fails  = 0;
  int nextVal = 1;
  logic [DATA_W-1:0] model[$];

  typedef struct packed {
    logic       isRd;
    logic       burst;
    logic [3:0] chan;
    logic [2:0] trail;
    logic       expErr;
    logic [4:0] expOcc;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 4'd3, 3'd0, 1'b0, 5'd1},
    '{1'b0, 1'b1, 4'd3, 3'd3, 1'b0, 5'd9},
    '{1'b0, 1'b1, 4'd5, 3'd1, 1'b1, 5'd9},
    '{1'b0, 1'b1, 4'd3, 3'd2, 1'b1, 5'd9},
    '{1'b0, 1'b0, 4'd3, 3'd4, 1'b0, 5'd10},
    '{1'b1, 1'b1, 4'd3, 3'd3, 1'b0, 5'd2},
    '{1'b1, 1'b1, 4'd3, 3'd0, 1'b1, 5'd2},
    '{1'b1, 1'b0, 4'd6, 3'd1, 1'b1, 5'd2},
    '{1'b1, 1'b0, 4'd3, 3'd1, 1'b0, 5'd1},
    '{1'b1, 1'b0, 4'd3, 3'd0, 1'b0, 5'd0},
    '{1'b1, 1'b0, 4'd3, 3'd2, 1'b1, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expStat(input int occ);
    int vac;
    vac = DEPTH - occ;
    return {occ == DEPTH, vac <= 1, occ >= DEPTH/2, occ == 0, 28'(vac), 4'b0};
  endfunction

  task automatic doWrite(input logic burst, input logic [3:0] chan, input int trail,
                         output int acks, output int errs);
    int since;
    bit started, pending;
    acks = 0; errs = 0; since = 0; started = 0; pending = 0;
    @(negedge clk);
    wrReq = 1'b1; wrBurst = burst; wrChan = chan; wrData = DATA_W'(nextVal);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (pending) begin
        nextVal++;
        wrData = DATA_W'(nextVal) ^ {4'h5, 32'h0};
        pending = 0;
      end
      if (wrAck) begin
        model.push_back(wrData);
        acks++; started = 1; since = 0; pending = 1;
      end else if (wrErrAck) begin
        errs++; started = 1; since = 0;
      end else if (started) begin
        since++;
        if (since > trail) wrReq = 1'b0;
        if (since >= trail + 4) break;
      end
    end
    wrReq = 1'b0;
  endtask

  task automatic doRead(input logic burst, input logic [3:0] chan, input int trail,
                        output int acks, output int errs);
    int since;
    bit started;
    logic [DATA_W-1:0] exp;
    acks = 0; errs = 0; since = 0; started = 0;
    @(negedge clk);
    rdReq = 1'b1; rdBurst = burst; rdChan = chan;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (rdValid) begin
        exp = (model.size() > 0) ? model.pop_front() : 'x;
        chk(rdData === exp, "R7 read order", 64'(rdData), 64'(exp));
      end
      if (rdAck) begin
        acks++; started = 1; since = 0;
      end else if (rdErrAck) begin
        errs++; started = 1; since = 0;
      end else if (started) begin
        since++;
        if (since > trail) rdReq = 1'b0;
        if (since >= trail + 4) break;
      end
    end
    rdReq = 1'b0;
  endtask

  task automatic readStat(output logic [DATA_W-1:0] w, output logic a);
    @(negedge clk);
    statReq = 1'b1;
    @(negedge clk);
    statReq = 1'b0;
    a = statAck;
    w = statWord;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: all requirements, actual timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    int acks, errs, expAcks;
    logic [DATA_W-1:0] sw;
    logic sa;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    chk(rdEmpty && rdAlmostEmpty && rdHalfEmpty, "R1 flags", {rdEmpty, rdAlmostEmpty, rdHalfEmpty}, 3'b111);
    chk(rdOccupancy == 0, "R1 occupancy", rdOccupancy, 0);
    chk(!wrAck && !wrErrAck && !rdAck && !rdErrAck && !rdValid, "R1 quiet",
        {wrAck, wrErrAck, rdAck, rdErrAck, rdValid}, 0);
    readStat(sw, sa);
    chk(sa == 1'b1, "R2 status ack", sa, 1);
    chk(sw == expStat(0), "R1 status empty", sw, expStat(0));

    // R5: channel-valid outputs
    wrChan = 4'd5; rdChan = 4'd3;
    #1;
    chk(!wrChanOk && rdChanOk, "R5 chanOk", {wrChanOk, rdChanOk}, 2'b01);

    // Vector table: R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isRd) doRead(VEC[i].burst, VEC[i].chan, int'(VEC[i].trail), acks, errs);
      else             doWrite(VEC[i].burst, VEC[i].chan, int'(VEC[i].trail), acks, errs);
      expAcks = VEC[i].expErr ? 0 : (VEC[i].burst ? BL : 1);
      chk(acks == expAcks, (VEC[i].trail != 0) ? "R4 ack count with trailing request" : "R3 ack count",
          64'(acks), 64'(expAcks));
      chk(errs == (VEC[i].expErr ? 1 : 0), VEC[i].chan != 4'd3 ? "R5 error ack" : "R6 error ack",
          64'(errs), 64'(VEC[i].expErr));
      chk(rdOccupancy == VEC[i].expOcc, "R9 occupancy", rdOccupancy, VEC[i].expOcc);
    end

    // R8 and R2: fill to full
    doWrite(1'b1, 4'd3, 1, acks, errs);
    doWrite(1'b1, 4'd3, 0, acks, errs);
    chk(rdOccupancy == 16, "R9 full occupancy", rdOccupancy, 16);
    readStat(sw, sa);
    chk(sw == expStat(16), "R8 status at full", sw, expStat(16));

    // R6: write rejected while full
    doWrite(1'b0, 4'd3, 0, acks, errs);
    chk(acks == 0 && errs == 1, "R6 write when full", {acks[7:0], errs[7:0]}, 16'h0001);
    chk(rdOccupancy == 16, "R6 occupancy kept", rdOccupancy, 16);

    // R8: one below full
    doRead(1'b0, 4'd3, 0, acks, errs);
    readStat(sw, sa);
    chk(sw == expStat(15), "R8 status at 15", sw, expStat(15));
    chk(!rdAlmostEmpty && !rdHalfEmpty, "R8 read flags at 15", {rdAlmostEmpty, rdHalfEmpty}, 0);

    // R9: concurrent read burst and write single
    fork
      begin
        int a1, e1;
        doRead(1'b1, 4'd3, 2, a1, e1);
        chk(a1 == BL, "R9 concurrent read acks", 64'(a1), BL);
      end
      begin
        int a2, e2;
        doWrite(1'b0, 4'd3, 1, a2, e2);
        chk(a2 == 1, "R9 concurrent write acks", 64'(a2), 1);
      end
    join
    chk(rdOccupancy == 8, "R9 occupancy after concurrent", rdOccupancy, 8);
    chk(rdHalfEmpty && !rdAlmostEmpty, "R8 half point read flags", {rdHalfEmpty, rdAlmostEmpty}, 2'b10);
    readStat(sw, sa);
    chk(sw == expStat(8), "R8 status at half", sw, expStat(8));

    // R7: drain in order
    doRead(1'b1, 4'd3, 0, acks, errs);
    chk(rdEmpty && rdOccupancy == 0, "R7 drained", {rdEmpty, rdOccupancy}, {1'b1, 5'd0});

    // R8: almost empty
    doWrite(1'b0, 4'd3, 0, acks, errs);
    chk(rdAlmostEmpty && rdHalfEmpty && !rdEmpty, "R8 one entry flags",
        {rdAlmostEmpty, rdHalfEmpty, rdEmpty}, 3'b110);
    readStat(sw, sa);
    chk(sw == expStat(1), "R2 status at one", sw, expStat(1));

    summary();
    $finish;
  end

endmodule